// File: doc/BRIEF.md
# Grouped Vector Float-to-Unsigned Truncating Converter

This block turns groups of vector registers that hold IEEE-754 single-precision lanes into unsigned 32-bit integers. Each conversion rounds toward zero and saturates values outside the target range. A command selects one of two group sizes, a pair or a quad of consecutive registers, and gives a source field and a destination field. The block expands each field into an aligned base register index. It then reads one source register per cycle from its internal register bank and converts every lane. Every result goes into a staging buffer. Only after the last source register has been converted does it write the destination registers, again one per cycle.

Because every read finishes before the first write, a group can be converted in place. Two sticky flags are collected over every lane of the group and held until the next command. One reports invalid conversions: NaN, overflow, or a negative value of magnitude one or more. The other reports inexact results, where a fraction was discarded. A host port loads and inspects the register bank between commands. A signed-select input is part of the command, but this block always produces unsigned results.

Top module: `fp2u_group_cvt`

## Requirements
- R1: A lane holds IEEE-754 single precision: sign in bit 31, biased exponent (bias 127) in bits 30:23, fraction in bits 22:0. Lane k of a register occupies bits 32k+31 down to 32k. A positive finite value below 2^32 becomes its integer part, truncated toward zero. It raises inexact exactly when a nonzero fraction was dropped.
- R2: A negative value of magnitude below 1, including -0.0, gives 0 and raises no invalid; it raises inexact when nonzero. A negative value of magnitude 1.0 or more gives 0 and raises invalid only.
- R3: Positive values of 2^32 or more and +infinity give 0xFFFFFFFF. Any NaN and -infinity give 0. All of these raise invalid only.
- R4: +0.0 gives 0 with no flag. A subnormal of either sign gives 0 and raises inexact only.
- R5: With grp_quad=0, the source and destination bases are twice their 4-bit fields. Lane k of register base+r (r = 0 or 1) lands in lane k of destination register base+r. No other register changes.
- R6: With grp_quad=1, each base is four times the low three bits of its field, and bit 3 of the field is ignored. Registers base to base+3 are converted lane for lane. No other register changes.
- R7: After reset, busy, done and both flags are 0. A start seen while idle raises busy in the next cycle. Busy stays high for exactly 4 cycles (pair) or 8 cycles (quad). It is followed by a single-cycle done pulse, and then the block is idle.
- R8: When the source and destination groups coincide, every destination register receives the conversion of the original source contents.
- R9: Both flags are cleared when a command is accepted. They accumulate as the OR over every lane of every register of the group, and hold their value after done until the next accepted command.
- R10: A start while busy or during the done cycle is ignored. The running command completes with unchanged timing, and no second command runs.
- R11: The bank resets to all zeros. A host write takes effect at the clock edge when the block is idle or in its done cycle, and is ignored while busy. The host read port returns the addressed register combinationally.
- R12: The want_signed input has no effect: negative inputs still follow R2 and produce unsigned results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, accepted when idle |
| grp_quad | input | 1 | 0: pair group, 1: quad group |
| src_fld | input | 4 | Source base field |
| dst_fld | input | 4 | Destination base field |
| want_signed | input | 1 | Signed-select from the command; ignored |
| busy | output | 1 | Conversion or writeback phase in progress |
| done | output | 1 | One-cycle pulse when the group is written |
| flag_invalid | output | 1 | Sticky invalid flag for the last command |
| flag_inexact | output | 1 | Sticky inexact flag for the last command |
| host_we | input | 1 | Host write enable for the register bank |
| host_widx | input | 5 | Host write register index |
| host_wdata | input | 128 | Host write data |
| host_ridx | input | 5 | Host read register index |
| host_rdata | output | 128 | Host read data (combinational) |

## Verification
On every cycle, the bound checker enforces the handshake. Busy lasts four or eight cycles to match the accepted group size. Done is a lone pulse that follows busy directly. Flags clear on acceptance and stay frozen while idle. Only the bench scenarios can show lane arithmetic, saturation and flag choice per input class. The same holds for base expansion from the fields, and for the way in-place groups read their sources. Blocked host writes, ignored starts and the inert signed select also show up only in those scenarios, in the contents of the register bank.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;
    localparam int unsigned ELEM_W  = 32;
    localparam int unsigned MAX_GRP = 4;
    localparam int unsigned CNT_W   = $clog2(MAX_GRP);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_WB   = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } cvt_flags_t;

    typedef struct packed {
        logic [ELEM_W-1:0] value;
        cvt_flags_t        flags;
    } lane_out_t;
endpackage

// File: rtl/fp2u_lane.sv
module fp2u_lane
    import fp2u_pkg::*;
(
    input  logic [ELEM_W-1:0] op_i,
    output lane_out_t         res_o
);
    localparam int unsigned EXP_W   = 8;
    localparam int unsigned MAN_W   = ELEM_W - EXP_W - 1;
    localparam int unsigned BIAS    = 127;
    localparam int unsigned SHIFT_W = ELEM_W + MAN_W;
    localparam int unsigned UE_W    = $clog2(ELEM_W);

    logic               sign;
    logic [EXP_W-1:0]   expo;
    logic [MAN_W-1:0]   man;
    logic [UE_W-1:0]    ue;
    logic [SHIFT_W-1:0] shifted;

    always_comb begin
        sign    = op_i[ELEM_W-1];
        expo    = op_i[ELEM_W-2 -: EXP_W];
        man     = op_i[MAN_W-1:0];
        ue      = UE_W'(expo - EXP_W'(BIAS));
        // hidden one placed at bit MAN_W, shifted by the unbiased exponent;
        // integer part lands above bit MAN_W-1, fraction below it
        shifted = {{(ELEM_W-1){1'b0}}, 1'b1, man} << ue;
        res_o   = '0;
        if (expo == '1) begin
            res_o.flags.invalid = 1'b1;
            if (man == '0 && !sign) begin
                res_o.value = '1;
            end
        end else if (expo == '0) begin
            res_o.flags.inexact = |man;
        end else if (expo < EXP_W'(BIAS)) begin
            res_o.flags.inexact = 1'b1;
        end else if (sign) begin
            res_o.flags.invalid = 1'b1;
        end else if (expo >= EXP_W'(BIAS + ELEM_W)) begin
            res_o.value         = '1;
            res_o.flags.invalid = 1'b1;
        end else begin
            res_o.value         = shifted[SHIFT_W-1 -: ELEM_W];
            res_o.flags.inexact = |shifted[MAN_W-1:0];
        end
    end
endmodule

// File: rtl/fp2u_vec.sv
module fp2u_vec
    import fp2u_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic [VLEN-1:0] vec_i,
    output logic [VLEN-1:0] vec_o,
    output cvt_flags_t      flags_o
);
    localparam int unsigned LANES = VLEN / ELEM_W;

    logic [LANES-1:0] inv_l;
    logic [LANES-1:0] inx_l;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_out_t lo;
        fp2u_lane u_lane (
            .op_i (vec_i[g*ELEM_W +: ELEM_W]),
            .res_o(lo)
        );
        assign vec_o[g*ELEM_W +: ELEM_W] = lo.value;
        assign inv_l[g]                  = lo.flags.invalid;
        assign inx_l[g]                  = lo.flags.inexact;
    end

    assign flags_o.invalid = |inv_l;
    assign flags_o.inexact = |inx_l;
endmodule

// File: rtl/fp2u_vreg_bank.sv
module fp2u_vreg_bank #(
    parameter int unsigned VLEN   = 128,
    parameter int unsigned RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [RIDX_W-1:0] widx_i,
    input  logic [VLEN-1:0]   wdata_i,
    input  logic [RIDX_W-1:0] ra_idx_i,
    output logic [VLEN-1:0]   ra_data_o,
    input  logic [RIDX_W-1:0] rb_idx_i,
    output logic [VLEN-1:0]   rb_data_o
);
    localparam int unsigned NREG = 1 << RIDX_W;

    logic [NREG-1:0][VLEN-1:0] regs_d;
    logic [NREG-1:0][VLEN-1:0] regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            regs_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data_o = regs_q[ra_idx_i];
    assign rb_data_o = regs_q[rb_idx_i];
endmodule

// File: rtl/fp2u_group_cvt.sv
module fp2u_group_cvt
    import fp2u_pkg::*;
#(
    parameter int unsigned VLEN   = 128,
    parameter int unsigned RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              grp_quad,
    input  logic [RIDX_W-2:0] src_fld,
    input  logic [RIDX_W-2:0] dst_fld,
    input  logic              want_signed,
    output logic              busy,
    output logic              done,
    output logic              flag_invalid,
    output logic              flag_inexact,
    input  logic              host_we,
    input  logic [RIDX_W-1:0] host_widx,
    input  logic [VLEN-1:0]   host_wdata,
    input  logic [RIDX_W-1:0] host_ridx,
    output logic [VLEN-1:0]   host_rdata
);
    localparam int unsigned FLD_W = RIDX_W - 1;

    typedef struct packed {
        phase_e                       phase;
        logic [CNT_W-1:0]             cnt;
        logic                         quad;
        logic [RIDX_W-1:0]            src_base;
        logic [RIDX_W-1:0]            dst_base;
        cvt_flags_t                   flags;
        logic [MAX_GRP-1:0][VLEN-1:0] stage;
    } ctl_t;

    ctl_t st_d;
    ctl_t st_q;

    logic              rf_we;
    logic [RIDX_W-1:0] rf_widx;
    logic [VLEN-1:0]   rf_wdata;
    logic [RIDX_W-1:0] eng_ridx;
    logic [VLEN-1:0]   eng_rdata;
    logic [VLEN-1:0]   conv_vec;
    cvt_flags_t        conv_flags;
    logic [CNT_W-1:0]  last_cnt;
    logic              unused_sel;

    assign unused_sel = want_signed;

    fp2u_vreg_bank #(
        .VLEN  (VLEN),
        .RIDX_W(RIDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (rf_we),
        .widx_i   (rf_widx),
        .wdata_i  (rf_wdata),
        .ra_idx_i (eng_ridx),
        .ra_data_o(eng_rdata),
        .rb_idx_i (host_ridx),
        .rb_data_o(host_rdata)
    );

    fp2u_vec #(
        .VLEN(VLEN)
    ) u_vec (
        .vec_i  (eng_rdata),
        .vec_o  (conv_vec),
        .flags_o(conv_flags)
    );

    always_comb begin
        st_d     = st_q;
        rf_we    = 1'b0;
        rf_widx  = host_widx;
        rf_wdata = host_wdata;
        last_cnt = st_q.quad ? CNT_W'(MAX_GRP - 1) : CNT_W'(1);
        eng_ridx = st_q.src_base + RIDX_W'(st_q.cnt);

        case (st_q.phase)
            PH_IDLE: begin
                rf_we = host_we;
                if (start) begin
                    st_d.phase = PH_CONV;
                    st_d.cnt   = '0;
                    st_d.quad  = grp_quad;
                    st_d.flags = '0;
                    if (grp_quad) begin
                        st_d.src_base = {src_fld[FLD_W-2:0], 2'b00};
                        st_d.dst_base = {dst_fld[FLD_W-2:0], 2'b00};
                    end else begin
                        st_d.src_base = {src_fld, 1'b0};
                        st_d.dst_base = {dst_fld, 1'b0};
                    end
                end
            end
            PH_CONV: begin
                st_d.stage[st_q.cnt] = conv_vec;
                st_d.flags.invalid   = st_q.flags.invalid | conv_flags.invalid;
                st_d.flags.inexact   = st_q.flags.inexact | conv_flags.inexact;
                if (st_q.cnt == last_cnt) begin
                    st_d.phase = PH_WB;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_WB: begin
                rf_we    = 1'b1;
                rf_widx  = st_q.dst_base + RIDX_W'(st_q.cnt);
                rf_wdata = st_q.stage[st_q.cnt];
                if (st_q.cnt == last_cnt) begin
                    st_d.phase = PH_DONE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_DONE: begin
                rf_we      = host_we;
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = (st_q.phase == PH_CONV) || (st_q.phase == PH_WB);
    assign done         = (st_q.phase == PH_DONE);
    assign flag_invalid = st_q.flags.invalid;
    assign flag_inexact = st_q.flags.inexact;
endmodule

// File: rtl/fp2u_group_cvt_chk.sv
module fp2u_group_cvt_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic grp_quad,
    input logic busy,
    input logic done,
    input logic flag_invalid,
    input logic flag_inexact
);
    logic       accepted;
    logic       quad_q;
    logic [3:0] bcnt_q;

    assign accepted = start && !busy && !done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quad_q <= 1'b0;
            bcnt_q <= '0;
        end else begin
            if (accepted) begin
                quad_q <= grp_quad;
            end
            bcnt_q <= busy ? bcnt_q + 4'd1 : 4'd0;
        end
    end

    assert_start_launches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> busy);

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt_q == (quad_q ? 4'd8 : 4'd4)));

    assert_done_follows_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_flags_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> (!flag_invalid && !flag_inexact));

    assert_flags_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accepted) |=> ($stable(flag_invalid) && $stable(flag_inexact)));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !busy);
endmodule

bind fp2u_group_cvt fp2u_group_cvt_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .grp_quad    (grp_quad),
    .busy        (busy),
    .done        (done),
    .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact)
);

// File: tb/test_fp2u_group_cvt.sv
`timescale 1ns/1ps
module test_fp2u_group_cvt;
    localparam int unsigned VLEN   = 128;
    localparam int unsigned RIDX_W = 5;
    localparam int          NVEC   = 20;
    localparam logic [VLEN-1:0] SENT = {4{32'hA5A5_5A5A}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              grp_quad = 1'b0;
    logic [3:0]        src_fld = '0;
    logic [3:0]        dst_fld = '0;
    logic              want_signed = 1'b0;
    logic              busy, done, flag_invalid, flag_inexact;
    logic              host_we = 1'b0;
    logic [RIDX_W-1:0] host_widx = '0;
    logic [VLEN-1:0]   host_wdata = '0;
    logic [RIDX_W-1:0] host_ridx = '0;
    logic [VLEN-1:0]   host_rdata;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    fp2u_group_cvt #(.VLEN(VLEN), .RIDX_W(RIDX_W)) i_fp2u_group_cvt (
        .clk(clk), .rst_n(rst_n), .start(start), .grp_quad(grp_quad),
        .src_fld(src_fld), .dst_fld(dst_fld), .want_signed(want_signed),
        .busy(busy), .done(done), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
        .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
        .host_ridx(host_ridx), .host_rdata(host_rdata)
    );

    // {input, expected, invalid, inexact}
    localparam logic [65:0] VEC [NVEC] = '{
        {32'h3F80_0000, 32'h0000_0001, 1'b0, 1'b0},  // 0  1.0        R1
        {32'h3FC0_0000, 32'h0000_0001, 1'b0, 1'b1},  // 1  1.5        R1
        {32'h3F00_0000, 32'h0000_0000, 1'b0, 1'b1},  // 2  0.5        R1
        {32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},  // 3  +0         R4
        {32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0},  // 4  -0         R2
        {32'hBF33_3333, 32'h0000_0000, 1'b0, 1'b1},  // 5  -0.7       R2
        {32'hBF80_0000, 32'h0000_0000, 1'b1, 1'b0},  // 6  -1.0       R2
        {32'h4F00_0000, 32'h8000_0000, 1'b0, 1'b0},  // 7  2^31       R1
        {32'h4F7F_FFFF, 32'hFFFF_FF00, 1'b0, 1'b0},  // 8  max below  R1
        {32'h4F80_0000, 32'hFFFF_FFFF, 1'b1, 1'b0},  // 9  2^32       R3
        {32'h7F80_0000, 32'hFFFF_FFFF, 1'b1, 1'b0},  // 10 +inf       R3
        {32'hFF80_0000, 32'h0000_0000, 1'b1, 1'b0},  // 11 -inf       R3
        {32'h7FC0_0000, 32'h0000_0000, 1'b1, 1'b0},  // 12 NaN        R3
        {32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1},  // 13 subnormal  R4
        {32'h42F7_8000, 32'h0000_007B, 1'b0, 1'b1},  // 14 123.75     R1
        {32'h4B80_0001, 32'h0100_0002, 1'b0, 1'b0},  // 15 2^24+2     R1
        {32'h8000_0001, 32'h0000_0000, 1'b0, 1'b1},  // 16 -subnormal R4
        {32'hC0A0_0000, 32'h0000_0000, 1'b1, 1'b0},  // 17 -5.0       R2
        {32'h4040_0000, 32'h0000_0003, 1'b0, 1'b0},  // 18 3.0        R1
        {32'h4B00_0000, 32'h0080_0000, 1'b0, 1'b0}   // 19 2^23       R1
    };

    function automatic string req_of(input int i);
        case (i)
            3, 13, 16:     return "R4";
            4, 5, 6, 17:   return "R2";
            9, 10, 11, 12: return "R3";
            default:       return "R1";
        endcase
    endfunction

    function automatic logic [VLEN-1:0] lin(input int a, input int b, input int c, input int d);
        return {VEC[d][65:34], VEC[c][65:34], VEC[b][65:34], VEC[a][65:34]};
    endfunction

    function automatic logic [VLEN-1:0] lexp(input int a, input int b, input int c, input int d);
        return {VEC[d][33:2], VEC[c][33:2], VEC[b][33:2], VEC[a][33:2]};
    endfunction

    function automatic logic [1:0] lflg(input int a, input int b, input int c, input int d);
        return VEC[a][1:0] | VEC[b][1:0] | VEC[c][1:0] | VEC[d][1:0];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input int idx, input logic [VLEN-1:0] data);
        @(negedge clk);
        host_we = 1'b1; host_widx = RIDX_W'(idx); host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_reg(input int idx, output logic [VLEN-1:0] v);
        host_ridx = RIDX_W'(idx);
        #1;
        v = host_rdata;
    endtask

    task automatic check_reg(input string req, input int idx, input logic [VLEN-1:0] exp);
        logic [VLEN-1:0] v;
        rd_reg(idx, v);
        check(req, $sformatf("reg %0d", idx), v, exp);
    endtask

    task automatic check_flags(input string req, input logic [1:0] exp);
        check(req, "flags {invalid,inexact}", VLEN'({flag_invalid, flag_inexact}), VLEN'(exp));
    endtask

    task automatic run_op(input logic q, input logic [3:0] s, input logic [3:0] d, input logic sg);
        int bc;
        @(negedge clk);
        start = 1'b1; grp_quad = q; src_fld = s; dst_fld = d; want_signed = sg;
        @(negedge clk);
        start = 1'b0; want_signed = 1'b0;
        bc = 0;
        while (busy && bc < 20) begin
            bc++;
            @(negedge clk);
        end
        check("R7", "busy cycles", VLEN'(bc), VLEN'(q ? 8 : 4));
        check("R7", "done after busy", VLEN'(done), VLEN'(1));
        @(negedge clk);
        check("R7", "idle after done", VLEN'({busy, done}), VLEN'(0));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] v;
        int bc;

        // reset state
        repeat (3) @(negedge clk);
        check("R7", "reset busy/done", VLEN'({busy, done}), VLEN'(0));
        check_flags("R9", 2'b00);
        check_reg("R11", 0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "idle after reset", VLEN'({busy, done}), VLEN'(0));

        // host write/read round trip
        wr_reg(30, SENT);
        check_reg("R11", 30, SENT);

        // lane table, each value spread over a pair: regs 2,3 -> 10,11
        for (int i = 0; i < NVEC; i++) begin
            wr_reg(2, {4{VEC[i][65:34]}});
            wr_reg(3, {4{VEC[i][65:34]}});
            run_op(1'b0, 4'd1, 4'd5, 1'b0);
            check_reg(req_of(i), 10, {4{VEC[i][33:2]}});
            check_reg(req_of(i), 11, {4{VEC[i][33:2]}});
            check_flags(req_of(i), VEC[i][1:0]);
        end

        // R5 pair addressing and lane mapping: regs 6,7 -> 12,13
        wr_reg(6, lin(0, 7, 14, 15));
        wr_reg(7, lin(18, 19, 8, 1));
        wr_reg(11, SENT);
        wr_reg(14, SENT);
        run_op(1'b0, 4'd3, 4'd6, 1'b0);
        check_reg("R5", 12, lexp(0, 7, 14, 15));
        check_reg("R5", 13, lexp(18, 19, 8, 1));
        check_reg("R5", 11, SENT);
        check_reg("R5", 14, SENT);

        // R6 quad, field bit 3 ignored: regs 4..7 -> 24..27
        wr_reg(4, lin(0, 1, 2, 3));
        wr_reg(5, lin(4, 5, 6, 7));
        wr_reg(6, lin(8, 9, 10, 11));
        wr_reg(7, lin(12, 13, 14, 15));
        wr_reg(23, SENT);
        wr_reg(28, SENT);
        run_op(1'b1, 4'b1001, 4'b1110, 1'b0);
        check_reg("R6", 24, lexp(0, 1, 2, 3));
        check_reg("R6", 25, lexp(4, 5, 6, 7));
        check_reg("R6", 26, lexp(8, 9, 10, 11));
        check_reg("R6", 27, lexp(12, 13, 14, 15));
        check_reg("R6", 23, SENT);
        check_reg("R6", 28, SENT);
        check_flags("R9", 2'b11);

        // R8 in-place quad: regs 8..11 -> 8..11
        wr_reg(8, lin(15, 14, 7, 18));
        wr_reg(9, lin(19, 8, 0, 1));
        wr_reg(10, lin(17, 16, 2, 5));
        wr_reg(11, lin(9, 3, 4, 12));
        run_op(1'b1, 4'd2, 4'd2, 1'b0);
        check_reg("R8", 8, lexp(15, 14, 7, 18));
        check_reg("R8", 9, lexp(19, 8, 0, 1));
        check_reg("R8", 10, lexp(17, 16, 2, 5));
        check_reg("R8", 11, lexp(9, 3, 4, 12));

        // R9 flags: clean group, then a group with one NaN and one 1.5
        wr_reg(2, lin(0, 3, 7, 8));
        wr_reg(3, lin(15, 18, 19, 4));
        run_op(1'b0, 4'd1, 4'd5, 1'b0);
        check_flags("R9", 2'b00);
        wr_reg(2, lin(0, 3, 12, 8));
        wr_reg(3, lin(15, 18, 19, 1));
        run_op(1'b0, 4'd1, 4'd5, 1'b0);
        check_flags("R9", 2'b11);
        repeat (3) @(negedge clk);
        check_flags("R9", 2'b11);
        wr_reg(2, lin(0, 3, 7, 8));
        wr_reg(3, lin(15, 18, 19, 4));
        run_op(1'b0, 4'd1, 4'd5, 1'b0);
        check_flags("R9", lflg(0, 3, 7, 8) | lflg(15, 18, 19, 4));

        // R10 / R11: start and host write while busy are ignored
        wr_reg(2, lin(14, 15, 18, 19));
        wr_reg(3, lin(7, 8, 0, 1));
        wr_reg(14, SENT);
        wr_reg(15, SENT);
        wr_reg(31, SENT);
        @(negedge clk);
        start = 1'b1; grp_quad = 1'b0; src_fld = 4'd1; dst_fld = 4'd5;
        @(negedge clk);
        start = 1'b0;
        bc = 0;
        while (busy && bc < 20) begin
            bc++;
            if (bc == 2) begin
                start = 1'b1; grp_quad = 1'b1; dst_fld = 4'd7;
                host_we = 1'b1; host_widx = 5'd31; host_wdata = '0;
            end else begin
                start = 1'b0; host_we = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; host_we = 1'b0;
        check("R10", "busy cycles with extra start", VLEN'(bc), VLEN'(4));
        check("R10", "done pulse", VLEN'(done), VLEN'(1));
        @(negedge clk);
        check("R10", "no second command", VLEN'({busy, done}), VLEN'(0));
        @(negedge clk);
        check("R10", "still idle", VLEN'(busy), VLEN'(0));
        check_reg("R10", 10, lexp(14, 15, 18, 19));
        check_reg("R10", 11, lexp(7, 8, 0, 1));
        check_reg("R10", 14, SENT);
        check_reg("R10", 15, SENT);
        check_reg("R11", 31, SENT);

        // R10: start in the done cycle is ignored
        @(negedge clk);
        start = 1'b1; grp_quad = 1'b0; src_fld = 4'd1; dst_fld = 4'd5;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        start = 1'b1; dst_fld = 4'd7;
        @(negedge clk);
        start = 1'b0;
        check("R10", "start in done cycle", VLEN'(busy), VLEN'(0));
        check_reg("R10", 14, SENT);

        // R12: signed select has no effect
        wr_reg(2, lin(17, 6, 11, 1));
        wr_reg(3, lin(5, 16, 18, 14));
        run_op(1'b0, 4'd1, 4'd5, 1'b1);
        check_reg("R12", 10, lexp(17, 6, 11, 1));
        check_reg("R12", 11, lexp(5, 16, 18, 14));
        check_flags("R12", lflg(17, 6, 11, 1) | lflg(5, 16, 18, 14));

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule